// File: doc/BRIEF.md
# Multi-Channel Compare Timer with Watchdog Reset

This block is a system timer. A free-running up-counter advances by one on every cycle in which the `tick` strobe is high. With a 1 MHz strobe, one count is one microsecond. Six compare channels each hold a match value. When the counter steps onto a channel's value, that channel raises a sticky status flag. The flag drives the channel's interrupt line while the channel's interrupt enable is set. Software can write a snapshot command, which copies the live counter into a holding register. That value can then be read without racing the counter.

The last channel (index 5) doubles as a watchdog. Software arms it and sets its match value to "snapshot + timeout". It refreshes the watchdog by moving that match value forward before the counter reaches it. The reset output fires only if, on the match, both the arm bit and channel 5's interrupt enable are set. When it fires, it produces a pulse several cycles wide and disarms itself. All compares use full-width equality, so "match minus counter" is taken modulo 2^32 and a deadline that lies past the counter wrap works unchanged.

The register port is single-cycle. A write takes effect at the clock edge where `reg_wr` is high. A read samples the addressed register at the edge where `reg_rd` is high and presents it on `reg_rdata` from the next cycle. The port has no stream interface, so there is no valid/ready back-pressure; every pin is plain control or status.

Top module: `mtimer_wdog`

## Requirements
- R1: The counter (read at offset 0x00) increments by exactly one at each clock edge where `tick` is high, and holds its value when `tick` is low.
- R2: Writing a value with bit 0 set to offset 0x30 copies the counter value present at that edge into the snapshot register at offset 0x34. The snapshot register then holds that value while the counter keeps running.
- R3: Channel i's match register sits at offset 0x08 + 4*i. When a tick moves the counter onto the match value, status bit i (offset 0x2C) becomes 1 from the next cycle. The bit stays set until software writes 1 to bit i of offset 0x2C; if a new match arrives in the same cycle as that write, the set wins.
- R4: Interrupt output `irq[i]` is high exactly while status bit i and bit i of the interrupt enable register (offset 0x24) are both 1.
- R5: Bit 0 of offset 0x28 arms the watchdog (1) or disarms it (0). While it is disarmed, a channel 5 match raises no reset, although status bit 5 and `irq[5]` still respond.
- R6: `wdog_rst` goes high in the cycle after a channel 5 match edge only if both the arm bit and interrupt enable bit 5 were set at that edge. It then stays high for exactly RST_W cycles (default 4).
- R7: The edge that fires the reset also clears the arm bit, so reading offset 0x28 afterwards returns 0 and the reset does not repeat.
- R8: Rewriting the channel 5 match value to a later count, before the counter reaches the old value, prevents a reset at the old value.
- R9: A read returns its data one cycle after `reg_rd`. The write-only offset 0x30 and every unmapped offset (for example 0x40) read as zero.
- R10: A synchronous reset clears the counter, the snapshot, all match values, status flags, interrupt enables, the arm bit and the reset pulse; `irq` and `wdog_rst` read 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count strobe; counter advances on edges where it is high |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; data appears on the next cycle |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 6 | Per-channel interrupt lines (status AND enable) |
| wdog_rst | output | 1 | Watchdog reset pulse, RST_W cycles wide |

## Verification
Each result has a fixed latency after its stimulus. Read data is due one cycle after the read strobe. Status flags and interrupt lines reflect a match in the cycle after the tick edge that moved the counter onto the value. The reset pulse starts in that same following cycle and lasts exactly RST_W cycles. The bench moves `tick` only through a task that counts edges, so every expected counter value follows from the number of ticks issued. The bench drives inputs on falling edges and pushes expected read data into a queue at the sampling edge. A monitor compares that data on the next falling edge. Pin checks and the cycle-by-cycle check of the pulse width are made on falling edges directly after the edge that causes them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register offsets; match channel i lives at OFS_MATCH0 + 4*i.
  localparam int OFS_COUNT  = 'h00;
  localparam int OFS_MATCH0 = 'h08;
  localparam int OFS_IRQEN  = 'h24;
  localparam int OFS_ARM    = 'h28;
  localparam int OFS_STATUS = 'h2C;
  localparam int OFS_SNAP   = 'h30;
  localparam int OFS_SNAPV  = 'h34;

  function automatic int match_ofs(input int ch);
    return OFS_MATCH0 + 4 * ch;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             snap_req,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] snap
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      if (tick)     cnt_q  <= cnt_nxt;
      if (snap_req) snap_q <= cnt_q;
    end
  end

  assign cnt  = cnt_q;
  assign snap = snap_q;
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] match_val,
  output logic             hit,
  output logic             status
);
  logic [CNT_W-1:0] val_q;
  logic             stat_q;

  // A hit is the edge that moves the counter onto the stored value.
  assign hit = tick && (cnt_nxt == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (val_wr) val_q <= wdata;
      if (hit)           stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
    end
  end

  assign match_val = val_q;
  assign status    = stat_q;
endmodule

// File: rtl/tmr_wdog_ctl.sv
module tmr_wdog_ctl #(
  parameter int RST_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_wr,
  input  logic arm_bit,
  input  logic wd_hit,
  input  logic wd_irq_en,
  output logic armed,
  output logic rst_pulse
);
  localparam int PW = $clog2(RST_W + 1);

  logic          arm_q;
  logic [PW-1:0] left_q;
  logic          fire;

  assign fire = wd_hit && arm_q && wd_irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      left_q <= '0;
    end else begin
      if (fire)        arm_q <= 1'b0;
      else if (arm_wr) arm_q <= arm_bit;
      if (fire)                   left_q <= PW'(RST_W);
      else if (left_q != '0)      left_q <= left_q - PW'(1);
    end
  end

  assign armed     = arm_q;
  assign rst_pulse = (left_q != '0);
endmodule

// File: rtl/mtimer_wdog.sv
module mtimer_wdog #(
  parameter int CNT_W  = 32,
  parameter int NCH    = 6,
  parameter int WD_CH  = 5,
  parameter int RST_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NCH-1:0]    irq,
  output logic              wdog_rst
);
  import tmr_pkg::*;

  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(OFS_IRQEN);
  localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFS_ARM);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_SNAP   = ADDR_W'(OFS_SNAP);
  localparam logic [ADDR_W-1:0] A_SNAPV  = ADDR_W'(OFS_SNAPV);

  logic [CNT_W-1:0] cnt, cnt_nxt, snap;
  logic [CNT_W-1:0] match_val [NCH];
  logic [NCH-1:0]   hit, status, ie_q;
  logic             wd_en, snap_req, ie_wr, arm_wr, stat_wr;
  logic [CNT_W-1:0] rd_mux;

  assign snap_req = reg_wr && (reg_addr == A_SNAP) && reg_wdata[0];
  assign ie_wr    = reg_wr && (reg_addr == A_IRQEN);
  assign arm_wr   = reg_wr && (reg_addr == A_ARM);
  assign stat_wr  = reg_wr && (reg_addr == A_STATUS);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .snap_req(snap_req),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .snap(snap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_wr;
    assign sel_wr = reg_wr && (reg_addr == ADDR_W'(match_ofs(g)));
    tmr_match_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .cnt_nxt(cnt_nxt),
      .val_wr(sel_wr), .wdata(reg_wdata),
      .stat_clr(stat_wr && reg_wdata[g]),
      .match_val(match_val[g]), .hit(hit[g]), .status(status[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        ie_q <= '0;
    else if (ie_wr) ie_q <= reg_wdata[NCH-1:0];
  end

  tmr_wdog_ctl #(.RST_W(RST_W)) u_wd (
    .clk(clk), .rst(rst), .arm_wr(arm_wr), .arm_bit(reg_wdata[0]),
    .wd_hit(hit[WD_CH]), .wd_irq_en(ie_q[WD_CH]),
    .armed(wd_en), .rst_pulse(wdog_rst)
  );

  assign irq = status & ie_q;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_COUNT:  rd_mux = cnt;
      A_IRQEN:  rd_mux = CNT_W'(ie_q);
      A_ARM:    rd_mux = CNT_W'(wd_en);
      A_STATUS: rd_mux = CNT_W'(status);
      A_SNAPV:  rd_mux = snap;
      default:  rd_mux = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == ADDR_W'(match_ofs(i))) rd_mux = match_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mtimer_wdog_chk.sv
module mtimer_wdog_chk #(
  parameter int CNT_W = 32,
  parameter int NCH   = 6,
  parameter int WD_CH = 5,
  parameter int RST_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             snap_req,
  input logic             stat_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] snap,
  input logic [NCH-1:0]   status,
  input logic [NCH-1:0]   ie_q,
  input logic             wd_en,
  input logic             wdog_rst
);
  logic [7:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst)           hi_len <= '0;
    else if (wdog_rst) hi_len <= hi_len + 8'd1;
    else               hi_len <= '0;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + CNT_W'(1))); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R1
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> $stable(snap)); // R2
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((status & $past(status)) == $past(status))); // R3
  AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst) |-> $past(wd_en && ie_q[WD_CH])); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    hi_len <= 8'(RST_W)); // R6
  AST_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst) |-> !wd_en); // R7
endmodule

bind mtimer_wdog mtimer_wdog_chk #(
  .CNT_W(CNT_W), .NCH(NCH), .WD_CH(WD_CH), .RST_W(RST_W)
) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .snap_req(snap_req), .stat_wr(stat_wr),
  .cnt(cnt), .snap(snap), .status(status), .ie_q(ie_q),
  .wd_en(wd_en), .wdog_rst(wdog_rst)
);

// File: tb/mtimer_wdog_tb_top.sv
`timescale 1ns/1ps
module mtimer_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [5:0]  irq;
  logic        wdog_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { string tag; logic [31:0] val; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  mtimer_wdog dut_i (
    .clk(clk), .rst(rst), .tick(tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq(irq), .wdog_rst(wdog_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares registered read data one cycle after the read strobe.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, reg_rdata, e.val);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk);
    e.tag = tag; e.val = exp;
    exp_q.push_back(e);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Issues n counter ticks; returns on the falling edge after the last one.
  task automatic tick_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 irq after reset", 32'(irq), 32'h0);
    check("R10 wdog_rst after reset", 32'(wdog_rst), 32'h0);
    rd(8'h00, 32'd0, "R10 counter after reset");
    rd(8'h28, 32'd0, "R10 arm after reset");

    tick_n(10);
    rd(8'h00, 32'd10, "R1 counter after 10 ticks");
    rd(8'h00, 32'd10, "R1 counter holds without tick");

    wr(8'h30, 32'h1);
    tick_n(5);
    rd(8'h34, 32'd10, "R2 snapshot holds");
    rd(8'h00, 32'd15, "R1 counter runs past snapshot");

    wr(8'h10, 32'd20);
    wr(8'h24, 32'h04);
    rd(8'h10, 32'd20, "R3 channel 2 match readback");
    tick_n(4);
    check("R4 irq before match", 32'(irq), 32'h0);
    tick_n(1);
    check("R4 irq on match ch2", 32'(irq), 32'h04);
    rd(8'h2C, 32'h04, "R3 status ch2 set");
    wr(8'h2C, 32'h04);
    check("R3 status clear drops irq", 32'(irq), 32'h0);

    wr(8'h0C, 32'd22);
    tick_n(2);
    check("R4 masked ch1 irq", 32'(irq), 32'h0);
    rd(8'h2C, 32'h02, "R3 masked ch1 status");
    wr(8'h2C, 32'h3F);

    rd(8'h40, 32'h0, "R9 unmapped reads zero");
    rd(8'h30, 32'h0, "R9 snapshot command reads zero");

    // Armed, interrupt enable 5 off: no reset. Counter is 22.
    wr(8'h24, 32'h0);
    wr(8'h28, 32'h1);
    wr(8'h1C, 32'd25);
    tick_n(3);
    check("R6 no reset without irq enable", 32'(wdog_rst), 32'h0);
    rd(8'h28, 32'h1, "R6 arm kept without fire");
    rd(8'h2C, 32'h20, "R3 status ch5 set");
    wr(8'h2C, 32'h3F);

    // Counter is 25: arm fully, then refresh before expiry.
    wr(8'h24, 32'h20);
    wr(8'h1C, 32'd29);
    tick_n(3);
    wr(8'h1C, 32'd31);
    tick_n(1);
    check("R8 refresh avoids reset", 32'(wdog_rst), 32'h0);
    tick_n(2);
    check("R6 reset pulse cycle 1", 32'(wdog_rst), 32'h1);
    check("R4 irq ch5 on watchdog match", 32'(irq), 32'h20);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      check($sformatf("R6 reset pulse cycle %0d", k), 32'(wdog_rst), 32'h1);
    end
    @(negedge clk);
    check("R6 reset pulse ends", 32'(wdog_rst), 32'h0);
    rd(8'h28, 32'h0, "R7 arm cleared by fire");

    // Disarmed: counter is 31.
    wr(8'h2C, 32'h3F);
    wr(8'h1C, 32'd33);
    tick_n(2);
    check("R5 disarmed no reset", 32'(wdog_rst), 32'h0);
    check("R5 disarmed irq still set", 32'(irq), 32'h20);

    wr(8'h24, 32'h3F);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 irq after mid reset", 32'(irq), 32'h0);
    rd(8'h24, 32'h0, "R10 irq enable cleared");
    rd(8'h00, 32'h0, "R10 counter cleared");
    rd(8'h1C, 32'h0, "R10 match cleared");

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule